// File: doc/BRIEF.md
# E3 Overhead Status Persistence Filter

This block sits behind the frame aligner of an E3 receiver. Once per received frame it accepts the captured maintenance-and-adaptation overhead byte and applies a separate consecutive-frame qualification rule to each field. It produces a debounced far-end receive failure state, a validated timing marker value and a flag that shows whether the payload type has changed recently. It also produces one-clock change pulses that a downstream interrupt block can consume.

Frames arrive on a valid/ready interface. `oh_valid` high for one clock presents one frame's byte. `oh_ready` is always high, so the block never applies back-pressure and the sender never has to hold a byte. A frame only counts while `in_frame` reports alignment. A byte that arrives while alignment is lost is consumed and discarded. The failure and timing marker thresholds can each be set, through their own configuration input, to a short run (3 frames by default) or a long run (5 frames by default).

Top module: `e3oh_persist`

## Requirements
- R1: After reset, `ferf_state`, `tmark_state`, `pt_change`, `ferf_chg` and `tmark_chg` are all 0.
- R2: The failure indication is bit 7 of `oh_byte`, which is the first bit on the line. `ferf_state` becomes 1 on the frame that completes a run of consecutive aligned frames with that bit at 1. The run length is 3 when `ferf_long` = 0 and 5 when `ferf_long` = 1.
- R3: `ferf_state` returns to 0 only on the frame that completes a run of the same selected length with bit 7 at 0.
- R4: A frame whose bit value differs from the value currently being counted restarts the run at 1 for the new value. A run that is broken before the threshold therefore changes nothing.
- R5: The timing marker is bit 0 of `oh_byte`. `tmark_state` takes a new marker value only after that value has held in 3 consecutive aligned frames (`tmark_long` = 0) or in 5 (`tmark_long` = 1).
- R6: The payload type is bits 5:3 of `oh_byte`. `pt_change` is 1 when any two adjacent frames among the last 5 aligned frames carry different payload types, and 0 when they all agree. History slots not yet filled since reset are never compared.
- R7: Frames are evaluated only when `oh_valid` and `in_frame` are both 1. Whenever `in_frame` is 0, the run counts restart and every declared output holds its value. Payload history is also left untouched.
- R8: `ferf_chg` and `tmark_chg` pulse high for exactly one clock, in the same cycle that `ferf_state` or `tmark_state` respectively takes a new value. They pulse at no other time.
- R9: `oh_ready` is 1 in every cycle, so no byte is ever refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oh_valid | input | 1 | One frame's overhead byte is present |
| oh_ready | output | 1 | Always 1; the block accepts every byte |
| oh_byte | input | 8 | Overhead byte; bit 7 is the first bit on the line |
| in_frame | input | 1 | Frame alignment held |
| ferf_long | input | 1 | Failure run length: 0 short, 1 long |
| tmark_long | input | 1 | Timing marker run length: 0 short, 1 long |
| ferf_state | output | 1 | Declared far-end receive failure |
| tmark_state | output | 1 | Validated timing marker value |
| pt_change | output | 1 | Payload type changed within the window |
| ferf_chg | output | 1 | One-clock pulse when `ferf_state` changes |
| tmark_chg | output | 1 | One-clock pulse when `tmark_state` changes |

## Verification
The bench builds the block with its default parameters: runs of 3 and 5 frames and a payload window of 5 entries. With these values, every threshold crossing, broken run and window drain takes only a handful of frames. This lets the bench reach both run-length settings for both fields, runs broken one frame short of the threshold, and payload changes as they enter and leave the window. It also reaches the partly filled history just after reset, and misaligned frames placed in the middle of runs.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
  localparam int unsigned OH_W      = 8;
  localparam int unsigned PT_W      = 3;
  localparam int unsigned FERF_POS  = 7;
  localparam int unsigned PT_LSB    = 3;
  localparam int unsigned TMARK_POS = 0;

  typedef struct packed {
    logic            ferf;
    logic [PT_W-1:0] ptype;
    logic            tmark;
  } oh_fields_t;

  function automatic oh_fields_t split_oh(input logic [OH_W-1:0] b);
    oh_fields_t f;
    f.ferf  = b[FERF_POS];
    f.ptype = b[PT_LSB +: PT_W];
    f.tmark = b[TMARK_POS];
    return f;
  endfunction
endpackage

// File: rtl/e3oh_run_filter.sv
module e3oh_run_filter #(
  parameter int unsigned N_SHORT = 3,
  parameter int unsigned N_LONG  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flush,
  input  logic sel_long,
  input  logic bit_in,
  output logic state_o,
  output logic chg_o
);
  localparam int unsigned CW = $clog2(N_LONG + 1);
  localparam logic [CW-1:0] CMAX = CW'(N_LONG);
  localparam logic [CW-1:0] CSHORT = CW'(N_SHORT);

  logic          cand_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] thr;
  logic          declare;

  assign thr = sel_long ? CMAX : CSHORT;

  always_comb begin
    if (bit_in == cand_q)
      cnt_nx = (cnt_q == CMAX) ? cnt_q : cnt_q + CW'(1);
    else
      cnt_nx = CW'(1);
  end

  assign declare = (cnt_nx >= thr) && (bit_in != state_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= 1'b0;
      cnt_q   <= '0;
      state_o <= 1'b0;
      chg_o   <= 1'b0;
    end else begin
      chg_o <= 1'b0;
      if (flush) begin
        cnt_q <= '0;
      end else if (tick) begin
        cand_q <= bit_in;
        cnt_q  <= cnt_nx;
        if (declare) begin
          state_o <= bit_in;
          chg_o   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/e3oh_pt_window.sv
module e3oh_pt_window #(
  parameter int unsigned PT_W  = 3,
  parameter int unsigned DEPTH = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PT_W-1:0] pt_in,
  output logic            changed_o
);
  localparam int unsigned NPAIR = DEPTH - 1;

  logic [PT_W-1:0] hist_q [DEPTH];
  logic [DEPTH-1:0] fill_q;
  logic [NPAIR-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (tick) begin
      hist_q[0] <= pt_in;
      fill_q    <= {fill_q[DEPTH-2:0], 1'b1};
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign diff[p] = fill_q[p] && fill_q[p+1] && (hist_q[p] != hist_q[p+1]);
    end
  endgenerate

  assign changed_o = |diff;
endmodule

// File: rtl/e3oh_persist.sv
module e3oh_persist #(
  parameter int unsigned FERF_SHORT = 3,
  parameter int unsigned FERF_LONG  = 5,
  parameter int unsigned TM_SHORT   = 3,
  parameter int unsigned TM_LONG    = 5,
  parameter int unsigned PT_DEPTH   = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       oh_valid,
  output logic                       oh_ready,
  input  logic [e3oh_pkg::OH_W-1:0]  oh_byte,
  input  logic                       in_frame,
  input  logic                       ferf_long,
  input  logic                       tmark_long,
  output logic                       ferf_state,
  output logic                       tmark_state,
  output logic                       pt_change,
  output logic                       ferf_chg,
  output logic                       tmark_chg
);
  import e3oh_pkg::*;

  oh_fields_t fld;
  logic       tick;
  logic       flush;

  assign oh_ready = 1'b1;
  assign fld      = split_oh(oh_byte);
  assign tick     = oh_valid && in_frame;
  assign flush    = !in_frame;

  e3oh_run_filter #(.N_SHORT(FERF_SHORT), .N_LONG(FERF_LONG)) u_ferf (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flush(flush),
    .sel_long(ferf_long), .bit_in(fld.ferf),
    .state_o(ferf_state), .chg_o(ferf_chg)
  );

  e3oh_run_filter #(.N_SHORT(TM_SHORT), .N_LONG(TM_LONG)) u_tmark (
    .clk(clk), .rst_n(rst_n), .tick(tick), .flush(flush),
    .sel_long(tmark_long), .bit_in(fld.tmark),
    .state_o(tmark_state), .chg_o(tmark_chg)
  );

  e3oh_pt_window #(.PT_W(PT_W), .DEPTH(PT_DEPTH)) u_pt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pt_in(fld.ptype), .changed_o(pt_change)
  );
endmodule

// File: rtl/e3oh_persist_chk.sv
module e3oh_persist_chk (
  input logic clk,
  input logic rst_n,
  input logic oh_valid,
  input logic oh_ready,
  input logic in_frame,
  input logic ferf_state,
  input logic tmark_state,
  input logic pt_change,
  input logic ferf_chg,
  input logic tmark_chg
);
  a_r9_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    oh_ready);
  a_r8_ferf_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ferf_chg |-> (ferf_state != $past(ferf_state)));
  a_r8_ferf_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ferf_state != $past(ferf_state)) |-> ferf_chg);
  a_r8_tmark_pulse_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    tmark_chg |-> (tmark_state != $past(tmark_state)));
  a_r8_tmark_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tmark_state != $past(tmark_state)) |-> tmark_chg);
  a_r8_ferf_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ferf_chg |=> !ferf_chg);
  a_r7_ferf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oh_valid && in_frame) |-> $stable(ferf_state));
  a_r7_tmark_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oh_valid && in_frame) |-> $stable(tmark_state));
  a_r6_pt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(oh_valid && in_frame) |-> $stable(pt_change));
endmodule

bind e3oh_persist e3oh_persist_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oh_valid(oh_valid), .oh_ready(oh_ready),
  .in_frame(in_frame), .ferf_state(ferf_state), .tmark_state(tmark_state),
  .pt_change(pt_change), .ferf_chg(ferf_chg), .tmark_chg(tmark_chg)
);

// File: tb/tb_e3oh_persist.sv
module tb_e3oh_persist;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       oh_valid = 1'b0;
  logic       oh_ready;
  logic [7:0] oh_byte = 8'h00;
  logic       in_frame = 1'b1;
  logic       ferf_long = 1'b0;
  logic       tmark_long = 1'b0;
  logic       ferf_state, tmark_state, pt_change, ferf_chg, tmark_chg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e3oh_persist dut (
    .clk(clk), .rst_n(rst_n), .oh_valid(oh_valid), .oh_ready(oh_ready),
    .oh_byte(oh_byte), .in_frame(in_frame), .ferf_long(ferf_long),
    .tmark_long(tmark_long), .ferf_state(ferf_state), .tmark_state(tmark_state),
    .pt_change(pt_change), .ferf_chg(ferf_chg), .tmark_chg(tmark_chg)
  );

  typedef struct {
    string tag;
    logic  ferf;
    logic  tm;
    logic  pt;
    logic  fp;
    logic  tp;
  } exp_t;
  exp_t q[$];
  string cur_tag = "R1";

  // reference model state, built from the requirements
  logic       m_fcand = 0, m_fstate = 0, m_tcand = 0, m_tstate = 0;
  int         m_fcnt = 0, m_tcnt = 0, m_fill = 0;
  logic [2:0] m_hist [5];
  logic       m_pt = 0;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mk(input logic f, input logic [2:0] pt, input logic tm);
    return {f, 1'b0, pt, 2'b00, tm};
  endfunction

  task automatic model(input logic [7:0] b, input logic al, output logic fp, output logic tp);
    fp = 0; tp = 0;
    if (!al) begin
      m_fcnt = 0; m_tcnt = 0;
    end else begin
      if (b[7] == m_fcand) m_fcnt = (m_fcnt < 5) ? m_fcnt + 1 : 5;
      else begin m_fcand = b[7]; m_fcnt = 1; end
      if (m_fcnt >= (ferf_long ? 5 : 3) && b[7] != m_fstate) begin m_fstate = b[7]; fp = 1; end
      if (b[0] == m_tcand) m_tcnt = (m_tcnt < 5) ? m_tcnt + 1 : 5;
      else begin m_tcand = b[0]; m_tcnt = 1; end
      if (m_tcnt >= (tmark_long ? 5 : 3) && b[0] != m_tstate) begin m_tstate = b[0]; tp = 1; end
      for (int i = 4; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = b[5:3];
      if (m_fill < 5) m_fill++;
      m_pt = 0;
      for (int i = 0; i + 1 < m_fill; i++) if (m_hist[i] != m_hist[i+1]) m_pt = 1;
    end
  endtask

  task automatic frame(input logic [7:0] b, input logic al);
    logic fp, tp;
    exp_t e;
    @(negedge clk);
    oh_byte = b; in_frame = al; oh_valid = 1'b1;
    model(b, al, fp, tp);
    @(posedge clk); #1;
    e = '{cur_tag, m_fstate, m_tstate, m_pt, fp, tp};
    q.push_back(e);
    @(negedge clk);
    oh_valid = 1'b0;
    @(posedge clk); #1;
    e = '{cur_tag, m_fstate, m_tstate, m_pt, 1'b0, 1'b0};
    q.push_back(e);
  endtask

  // monitor: compare outputs with the scoreboard between edges
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "ferf_state", ferf_state, e.ferf);
      check(e.tag, "tmark_state", tmark_state, e.tm);
      check(e.tag, "pt_change", pt_change, e.pt);
      check({e.tag, "/R8"}, "ferf_chg", ferf_chg, e.fp);
      check({e.tag, "/R8"}, "tmark_chg", tmark_chg, e.tp);
      check("R9", "oh_ready", oh_ready, 1'b1);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_hist[i] = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", "ferf_state", ferf_state, 1'b0);
    check("R1", "tmark_state", tmark_state, 1'b0);
    check("R1", "pt_change", pt_change, 1'b0);
    check("R1", "ferf_chg", ferf_chg, 1'b0);
    check("R1", "tmark_chg", tmark_chg, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R6: partially filled history is not compared
    cur_tag = "R6";
    frame(mk(0, 3'd2, 0), 1);
    frame(mk(0, 3'd2, 0), 1);
    // R2: short failure run
    cur_tag = "R2";
    for (int i = 0; i < 3; i++) frame(mk(1, 3'd2, 0), 1);
    // R3: short clear run
    cur_tag = "R3";
    for (int i = 0; i < 3; i++) frame(mk(0, 3'd2, 0), 1);
    // R4: broken runs
    cur_tag = "R4";
    frame(mk(1, 3'd2, 0), 1); frame(mk(1, 3'd2, 0), 1); frame(mk(0, 3'd2, 0), 1);
    for (int i = 0; i < 3; i++) frame(mk(1, 3'd2, 0), 1);
    frame(mk(0, 3'd2, 0), 1); frame(mk(0, 3'd2, 0), 1); frame(mk(1, 3'd2, 0), 1);
    // R2/R3: long runs
    ferf_long = 1'b1;
    cur_tag = "R3";
    for (int i = 0; i < 5; i++) frame(mk(0, 3'd2, 0), 1);
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) frame(mk(1, 3'd2, 0), 1);
    cur_tag = "R3";
    for (int i = 0; i < 5; i++) frame(mk(0, 3'd2, 0), 1);
    // R5: timing marker, both lengths
    cur_tag = "R5";
    frame(mk(0, 3'd2, 1), 1); frame(mk(0, 3'd2, 1), 1); frame(mk(0, 3'd2, 0), 1);
    for (int i = 0; i < 3; i++) frame(mk(0, 3'd2, 1), 1);
    tmark_long = 1'b1;
    for (int i = 0; i < 4; i++) frame(mk(0, 3'd2, 0), 1);
    frame(mk(0, 3'd2, 1), 1);
    for (int i = 0; i < 5; i++) frame(mk(0, 3'd2, 0), 1);
    // R6: payload type entering and draining the window
    cur_tag = "R6";
    frame(mk(0, 3'd5, 0), 1);
    for (int i = 0; i < 6; i++) frame(mk(0, 3'd5, 0), 1);
    frame(mk(0, 3'd1, 0), 1); frame(mk(0, 3'd5, 0), 1);
    for (int i = 0; i < 6; i++) frame(mk(0, 3'd5, 0), 1);
    // R7: misaligned frames ignored and runs restarted
    cur_tag = "R7";
    ferf_long = 1'b0; tmark_long = 1'b0;
    frame(mk(1, 3'd5, 1), 1); frame(mk(1, 3'd5, 1), 1);
    frame(mk(1, 3'd7, 1), 0);
    frame(mk(1, 3'd5, 1), 1); frame(mk(1, 3'd5, 1), 1);
    frame(mk(0, 3'd0, 0), 0);
    frame(mk(1, 3'd5, 1), 1); frame(mk(1, 3'd5, 1), 1); frame(mk(1, 3'd5, 1), 1);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule